// File: doc/BRIEF.md
# Non-Restoring Divide Sequencer

This block divides an unsigned 64-bit dividend by an unsigned 32-bit divisor. It returns a 32-bit quotient and a 32-bit remainder. The work is spread over many clock cycles. Each cycle runs one divide step. In that step an adder either adds the divisor to a signed partial remainder or subtracts it. A single status bit chooses between the two, and the adder's sign outcome refreshes that bit after every step. Once the last step is done, one correction cycle adds the divisor back if the partial remainder ended negative. The same cycle adjusts the quotient by one.

A caller presents the operands, sets the mode and pulses `start` while the block is idle. A `done` pulse marks the cycle in which results become visible. The results stay on the outputs until the next division completes. Two operand cases are refused: a divisor of zero, and a high dividend half not below the divisor, whose quotient would not fit in 32 bits. For these the block raises `overflow` and finishes almost at once. A remainder-only mode skips all quotient bookkeeping.

Top module: `ndiv_seq`

## Requirements
- R1: For every divisor D ≠ 0 with dividend[63:32] < D, `quotient` equals floor(dividend / D) and `remainder` equals dividend mod D in full mode (`rem_only` = 0 at start).
- R2: An accepted legal division raises `done` for exactly one cycle. `done` goes high 34 clock edges after the edge that sampled `start`.
- R3: If dividend[63:32] ≥ divisor and the divisor is nonzero, the block sets `overflow` = 1. It then drives `quotient` = 0 and `remainder` = 0, with `done` high 1 edge after the start edge.
- R4: A divisor of zero gives the same overflow response as R3 (flag 1, zero results, `done` after 1 edge).
- R5: With `rem_only` = 1 at start, `quotient` reads 0, `remainder` equals the full-mode remainder, and the latency stays at 34 edges.
- R6: A `start` pulse arriving while a division is in progress is ignored. The running division's results and timing are unchanged, and no extra `done` follows.
- R7: `quotient`, `remainder` and `overflow` hold their values between completions, and `done` stays low meanwhile. A legal division that follows an overflow clears `overflow` to 0.
- R8: During reset, `done`, `overflow`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division; honoured only while idle |
| rem_only | input | 1 | 1 = compute the remainder only, sampled with start |
| dividend | input | 64 | Unsigned dividend, sampled with start |
| divisor | input | 32 | Unsigned divisor, sampled with start |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Last division was refused (zero divisor or quotient too wide) |
| quotient | output | 32 | Unsigned quotient of the last division |
| remainder | output | 32 | Unsigned remainder of the last division |

## Verification
The assertions on the partial-remainder range take two things for granted. First, every division that starts stepping meets the no-overflow condition, so the high dividend half is below a nonzero divisor. Second, the latched divisor does not change until the division finishes. The bench steers every operand pair through the block's own overflow check: refused pairs never reach the step path, and all other pairs satisfy the range precondition. A second `start` is injected in the middle of a division. This shows that the latched operands stay fixed while the assertions rely on them.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIX  = 2'd2,
    ST_OUT  = 2'd3
  } ndiv_state_t;
endpackage

// File: rtl/ndiv_step.sv
// One non-restoring step: shift the next dividend bit into the partial
// remainder, then add or subtract the divisor as the status bit says.
module ndiv_step #(
  parameter int W = 32
) (
  input  logic [W+1:0] prem,
  input  logic         next_bit,
  input  logic [W-1:0] dvs,
  input  logic         sub,
  output logic [W+1:0] prem_nx,
  output logic         stat_nx
);
  logic [W+1:0] shifted;
  logic [W+1:0] dvs_ext;

  always_comb begin
    shifted = {prem[W:0], next_bit};
    dvs_ext = {2'b00, dvs};
    prem_nx = sub ? (shifted - dvs_ext) : (shifted + dvs_ext);
    // A borrow on subtract or no carry on add both leave a negative result.
    stat_nx = ~prem_nx[W+1];
  end
endmodule

// File: rtl/ndiv_qacc.sv
// Quotient accumulator kept in negated form: a subtract step counts down,
// an add step counts up, and the final add-back increments once.
module ndiv_qacc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step_en,
  input  logic         fix_en,
  input  logic         sub,
  output logic [W-1:0] acc
);
  logic [W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr)
      acc_d = '0;
    else if (step_en)
      acc_d = {acc_q[W-2:0], 1'b0} + (sub ? {W{1'b1}} : W'(1));
    else if (fix_en)
      acc_d = acc_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R1
  qacc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en && fix_en));
endmodule

// File: rtl/ndiv_ctrl.sv
module ndiv_ctrl
  import ndiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bad,
  output ndiv_state_t state,
  output logic        accept
);
  localparam int CW = $clog2(W);

  ndiv_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign accept = (st_q == ST_IDLE) && start;
  assign last   = (cnt_q == CW'(W - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = bad ? ST_OUT : ST_STEP;
        cnt_d = '0;
      end
      ST_STEP: begin
        cnt_d = cnt_q + CW'(1);
        if (last) st_d = ST_FIX;
      end
      ST_FIX:  st_d = ST_OUT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;

  // R3
  bad_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad) |=> (st_q == ST_OUT));

  // R2
  fix_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FIX) |-> $past(st_q == ST_STEP));
endmodule

// File: rtl/ndiv_seq.sv
module ndiv_seq
  import ndiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           rem_only,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           done,
  output logic           overflow,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder
);
  localparam int PW = W + 2;

  logic [1:0] rsync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_s = rsync[1];

  ndiv_state_t state;
  logic accept, bad;
  logic [PW-1:0] prem_q, prem_d, step_rem;
  logic [W-1:0]  lo_q, lo_d, dvs_q, dvs_d, acc;
  logic stat_q, stat_d, step_stat, mode_q, mode_d, bad_q, bad_d;
  logic done_d, ovf_d;
  logic [W-1:0] quo_d, rem_d;

  assign bad = (divisor == '0) || (dividend[2*W-1:W] >= divisor);

  ndiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .start(start), .bad(bad),
    .state(state), .accept(accept)
  );

  ndiv_step #(.W(W)) u_step (
    .prem(prem_q), .next_bit(lo_q[W-1]), .dvs(dvs_q), .sub(stat_q),
    .prem_nx(step_rem), .stat_nx(step_stat)
  );

  ndiv_qacc #(.W(W)) u_qacc (
    .clk(clk), .rst_n(rst_s), .clr(accept),
    .step_en((state == ST_STEP) && !mode_q),
    .fix_en((state == ST_FIX) && !stat_q && !mode_q),
    .sub(stat_q), .acc(acc)
  );

  always_comb begin
    prem_d = prem_q;
    lo_d   = lo_q;
    dvs_d  = dvs_q;
    stat_d = stat_q;
    mode_d = mode_q;
    bad_d  = bad_q;
    if (accept) begin
      prem_d = {2'b00, dividend[2*W-1:W]};
      lo_d   = dividend[W-1:0];
      dvs_d  = divisor;
      stat_d = 1'b1;
      mode_d = rem_only;
      bad_d  = bad;
    end else begin
      case (state)
        ST_STEP: begin
          prem_d = step_rem;
          lo_d   = {lo_q[W-2:0], 1'b0};
          stat_d = step_stat;
        end
        ST_FIX: if (!stat_q) prem_d = prem_q + {2'b00, dvs_q};
        default: ;
      endcase
    end
  end

  always_comb begin
    done_d = (state == ST_OUT);
    ovf_d  = overflow;
    quo_d  = quotient;
    rem_d  = remainder;
    if (state == ST_OUT) begin
      ovf_d = bad_q;
      quo_d = (bad_q || mode_q) ? '0 : ('0 - acc);
      rem_d = bad_q ? '0 : prem_q[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      prem_q    <= '0;
      lo_q      <= '0;
      dvs_q     <= '0;
      stat_q    <= 1'b0;
      mode_q    <= 1'b0;
      bad_q     <= 1'b0;
      done      <= 1'b0;
      overflow  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      prem_q    <= prem_d;
      lo_q      <= lo_d;
      dvs_q     <= dvs_d;
      stat_q    <= stat_d;
      mode_q    <= mode_d;
      bad_q     <= bad_d;
      done      <= done_d;
      overflow  <= ovf_d;
      quotient  <= quo_d;
      remainder <= rem_d;
    end
  end

  // R1
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state == ST_STEP) |=> (($signed(prem_q) < $signed({2'b00, dvs_q})) &&
                            ($signed(prem_q) >= -$signed({2'b00, dvs_q}))));

  // R1
  final_rem_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state == ST_OUT) |-> (bad_q || (!prem_q[PW-1] && (prem_q < {2'b00, dvs_q}))));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);

  // R3
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && overflow) |-> (quotient == '0 && remainder == '0));

  // R5
  rem_mode_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && mode_q) |-> (quotient == '0));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state != ST_IDLE) |=> $stable(dvs_q));
endmodule

// File: tb/ndiv_seq_bench.sv
module ndiv_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rem_only = 1'b0;
  logic [63:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        done, overflow;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ndiv_seq u_ndiv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rem_only(rem_only),
    .dividend(dividend), .divisor(divisor), .done(done),
    .overflow(overflow), .quotient(quotient), .remainder(remainder)
  );

  // {dividend, divisor, rem_only}
  localparam logic [96:0] VEC [0:9] = '{
    {64'd100,                    32'd7,            1'b0},
    {64'h0000_0001_0000_0000,    32'd3,            1'b0},
    {64'hFFFF_FFFE_FFFF_FFFF,    32'hFFFF_FFFF,    1'b0},
    {64'd12345,                  32'd1,            1'b0},
    {64'd5,                      32'd9,            1'b0},
    {64'h1234_5678_9ABC_DEF0,    32'h8765_4321,    1'b1},
    {64'h0000_0005_0000_0000,    32'd5,            1'b0},
    {64'h0000_0000_0000_0042,    32'd0,            1'b0},
    {64'h1234_5678_9ABC_DEF0,    32'h8765_4321,    1'b0},
    {64'h8000_0000_0000_0001,    32'h8000_0001,    1'b1}
  };

  function automatic void check(input bit ok, input string req, input string what,
                                input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  task automatic issue(input logic [63:0] dd, input logic [31:0] dv, input logic mo);
    @(negedge clk);
    dividend = dd; divisor = dv; rem_only = mo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    forever begin
      @(posedge clk); #1;
      lat++;
      if (done) break;
      if (lat > 200) begin
        check(1'b0, "R2", "watchdog on done", 64'(lat), 64'd34);
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] hq, hr;
    logic        hov;
    int seen;

    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check(done == 1'b0,      "R8", "done in reset", 64'(done), 64'd0);
    check(overflow == 1'b0,  "R8", "overflow in reset", 64'(overflow), 64'd0);
    check(quotient == '0,    "R8", "quotient in reset", 64'(quotient), 64'd0);
    check(remainder == '0,   "R8", "remainder in reset", 64'(remainder), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      logic [63:0] dd;
      logic [31:0] dv;
      logic        mo, eo;
      logic [31:0] eq, er;
      int          el;
      string       rq;
      {dd, dv, mo} = VEC[i];
      eo = (dv == 32'd0) || (dd[63:32] >= dv);
      eq = 32'd0; er = 32'd0;
      if (!eo) begin
        er = 32'(dd % {32'd0, dv});
        eq = mo ? 32'd0 : 32'(dd / {32'd0, dv});
      end
      el = eo ? 1 : 34;
      rq = eo ? ((dv == 32'd0) ? "R4" : "R3") : (mo ? "R5" : "R1");
      issue(dd, dv, mo);
      wait_done(lat);
      check(lat == el,         eo ? rq : "R2", "latency", 64'(lat), 64'(el));
      check(overflow == eo,    eo ? rq : "R7", "overflow flag", 64'(overflow), 64'(eo));
      check(quotient == eq,    rq, "quotient", 64'(quotient), 64'(eq));
      check(remainder == er,   rq, "remainder", 64'(remainder), 64'(er));
      @(posedge clk); #1;
      check(done == 1'b0,      "R2", "done one cycle", 64'(done), 64'd0);
    end

    // R7 hold between completions
    hq = quotient; hr = remainder; hov = overflow; seen = 0;
    repeat (15) begin
      @(posedge clk); #1;
      if (done) seen++;
    end
    check(quotient == hq,  "R7", "quotient hold", 64'(quotient), 64'(hq));
    check(remainder == hr, "R7", "remainder hold", 64'(remainder), 64'(hr));
    check(overflow == hov, "R7", "overflow hold", 64'(overflow), 64'(hov));
    check(seen == 0,       "R7", "done idle", 64'(seen), 64'd0);

    // R6 start while busy is ignored
    fork
      begin
        repeat (6) @(negedge clk);
        dividend = 64'd999; divisor = 32'd10; rem_only = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join_none
    issue(64'h0000_0003_0000_0007, 32'h0000_1000, 1'b0);
    wait_done(lat);
    check(lat == 34, "R6", "latency with busy start", 64'(lat), 64'd34);
    check(quotient == 32'(64'h0000_0003_0000_0007 / 64'h1000), "R6", "quotient with busy start",
          64'(quotient), 64'h0000_0003_0000_0007 / 64'h1000);
    check(remainder == 32'(64'h0000_0003_0000_0007 % 64'h1000), "R6", "remainder with busy start",
          64'(remainder), 64'h0000_0003_0000_0007 % 64'h1000);
    seen = 0;
    repeat (40) begin
      @(posedge clk); #1;
      if (done) seen++;
    end
    check(seen == 0, "R6", "no extra done", 64'(seen), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule